// File: doc/BRIEF.md
# Double-Buffered Endpoint Transmit Buffer with DMA Fill

This block sits between a DMA controller and a USB serial engine on the transmit side of one endpoint. The DMA controller writes packet data into it one byte per transfer. The serial engine reads it out one packet at a time. Two packet buffers of 64 bytes are used in turn. While the engine sends one buffer, the DMA controller can fill the other.

A request line asks the DMA controller for data. It is active only while software has set the DMA enable bit and the buffer being filled still has room. When a buffer receives its 64th byte, the block commits it for transmission without software help. The request then moves straight on to the other buffer. A shorter packet is committed only when the CPU pulses its commit strobe.

The drain side presents committed packets in the order they were committed, together with their byte counts. A buffer returns to the free state once all of its bytes have been read and the engine signals that transmission is done. An empty-buffer status drives an interrupt line that is gated only by its own enable input. Enabling DMA does not mask that interrupt.

Top module: `ep_txdb_fifo`

## Requirements
- R1: The control register resets to 0x00. Bit 1 is the DMA enable and is writable. Every other bit (7 to 2, and 0) reads as zero whatever is written.
- R2: `dma_req` is high only when the enable bit is set and the buffer being filled is not committed. When both buffers are committed, it is low.
- R3: Each `dma_ack` sampled while `dma_req` is high stores exactly one byte at the next free position of the fill buffer. A `dma_ack` while `dma_req` is low stores nothing.
- R4: The edge that stores the 64th byte of a buffer commits that buffer. In the following cycle `tx_valid` is high with `tx_count` = 64, provided no earlier packet is waiting.
- R5: After an automatic commit, `dma_req` stays high in the very next cycle when the other buffer is free. A run of back-to-back acknowledged writes continues without a gap.
- R6: A buffer holding 1 to 63 bytes is never committed on its own. It is committed by `cpu_commit`. A `cpu_commit` while the fill buffer holds zero bytes is ignored.
- R7: Packets appear on the drain side in commit order. Within a packet, `tx_data` shows the bytes in write order, advancing on each `tx_rd`.
- R8: `tx_done` frees the current drain buffer only after all `tx_count` bytes have been read. An earlier `tx_done` leaves `tx_valid` and `tx_count` unchanged.
- R9: A `cpu_clear` pulse empties both buffers and resets the fill and drain positions. `dma_req` is low in the cycle after the pulse and returns the cycle after that if DMA is enabled.
- R10: `buf_empty` is high when at least one buffer holds no data and is not committed. `irq` equals `buf_empty` AND `irq_en`, whatever the DMA enable bit is.
- R11: A `cpu_commit` in the same cycle as an accepted DMA write commits the buffer including that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data (bit 1 = DMA enable) |
| cfg_rdata | output | 8 | Control register read value |
| cpu_commit | input | 1 | CPU packet-commit strobe for the fill buffer |
| cpu_clear | input | 1 | Write-one clear of both buffers |
| irq_en | input | 1 | Interrupt enable for the empty-buffer interrupt |
| dma_req | output | 1 | Transfer request to the DMA controller |
| dma_ack | input | 1 | One-byte DMA write strobe |
| dma_data | input | 8 | DMA write byte |
| tx_valid | output | 1 | A committed packet is ready on the drain side |
| tx_count | output | 7 | Byte count of the presented packet (0 to 64) |
| tx_data | output | 8 | Byte at the current read position |
| tx_rd | input | 1 | Advance the read position by one byte |
| tx_done | input | 1 | Transmit-done pulse from the serial engine |
| buf_empty | output | 1 | At least one buffer is free and empty |
| irq | output | 1 | Empty-buffer interrupt, gated by irq_en |

## Verification
The hardest state to reach is the one where both buffers are committed and the request line must be low. Only then can an acknowledge arriving with no request be shown to store nothing. The stimulus gets there by filling two full packets back to back while the drain side stays idle. That same run shows the request surviving the first automatic commit with no gap. A second hard case is a CPU commit that lands in the same cycle as a DMA byte. It is driven directly and checked through the reported packet length.

// File: rtl/ep_tx_pkg.sv
package ep_tx_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CFG_W  = 8;
  localparam int unsigned EN_BIT = 1;
  localparam int unsigned NBUF   = 2;

  typedef enum logic [0:0] {
    BUF_OPEN  = 1'b0,
    BUF_READY = 1'b1
  } buf_state_e;
endpackage

// File: rtl/ep_tx_ctrl.sv
module ep_tx_ctrl
  import ep_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             cpu_clear,
  output logic [CFG_W-1:0] cfg_rdata,
  output logic             dma_en,
  output logic             clr_hold
);
  logic en_q, en_n;
  logic hold_q, hold_n;

  always_comb begin
    en_n   = en_q;
    if (cfg_we) en_n = cfg_wdata[EN_BIT];
    hold_n = cpu_clear;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      en_q   <= en_n;
      hold_q <= hold_n;
    end
  end

  always_comb begin
    cfg_rdata         = '0;
    cfg_rdata[EN_BIT] = en_q;
  end

  assign dma_en   = en_q;
  assign clr_hold = hold_q;
endmodule

// File: rtl/ep_tx_bank.sv
module ep_tx_bank #(
  parameter  int unsigned DEPTH = 64,
  parameter  int unsigned DW    = 8,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/ep_tx_seq.sv
module ep_tx_seq
  import ep_tx_pkg::*;
#(
  parameter  int unsigned DEPTH = 64,
  localparam int unsigned CW    = $clog2(DEPTH + 1),
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            dma_en,
  input  logic            hold,
  input  logic            dma_ack,
  input  logic            cpu_commit,
  input  logic            tx_rd,
  input  logic            tx_done,
  output logic            dma_req,
  output logic [NBUF-1:0] wr_en,
  output logic [AW-1:0]   wr_addr,
  output logic            rd_sel,
  output logic [AW-1:0]   rd_addr,
  output logic            tx_valid,
  output logic [CW-1:0]   tx_count,
  output logic            buf_empty
);
  buf_state_e    st_q  [NBUF];
  buf_state_e    st_n  [NBUF];
  logic [CW-1:0] cnt_q [NBUF];
  logic [CW-1:0] cnt_n [NBUF];
  logic          fsel_q, fsel_n;
  logic          dsel_q, dsel_n;
  logic [CW-1:0] ridx_q, ridx_n;

  logic          fill_open, last_byte, wr_go, cmt_go;
  logic          drn_ready, rd_go, fin_go;
  logic [CW-1:0] fill_cnt, drn_cnt;

  // fill-side decisions
  always_comb begin
    fill_open = (st_q[fsel_q] == BUF_OPEN);
    fill_cnt  = cnt_q[fsel_q];
    dma_req   = dma_en & fill_open & ~hold;
    wr_go     = dma_ack & dma_req & ~clr;
    last_byte = (fill_cnt == CW'(DEPTH - 1));
    cmt_go    = (wr_go & last_byte)
              | (cpu_commit & fill_open & ~clr & ((fill_cnt != '0) | wr_go));
  end

  // drain-side decisions
  always_comb begin
    drn_ready = (st_q[dsel_q] == BUF_READY);
    drn_cnt   = cnt_q[dsel_q];
    rd_go     = tx_rd & drn_ready & (ridx_q != drn_cnt) & ~clr;
    fin_go    = tx_done & drn_ready & (ridx_q == drn_cnt) & ~clr;
  end

  // next state
  always_comb begin
    fsel_n = fsel_q;
    dsel_n = dsel_q;
    ridx_n = ridx_q;
    for (int i = 0; i < NBUF; i++) begin
      st_n[i]  = st_q[i];
      cnt_n[i] = cnt_q[i];
      if (wr_go && (int'(fsel_q) == i)) cnt_n[i] = fill_cnt + CW'(1);
      if (cmt_go && (int'(fsel_q) == i)) st_n[i] = BUF_READY;
      if (fin_go && (int'(dsel_q) == i)) begin
        st_n[i]  = BUF_OPEN;
        cnt_n[i] = '0;
      end
      if (clr) begin
        st_n[i]  = BUF_OPEN;
        cnt_n[i] = '0;
      end
    end
    if (cmt_go) fsel_n = ~fsel_q;
    if (rd_go)  ridx_n = ridx_q + CW'(1);
    if (fin_go) begin
      ridx_n = '0;
      dsel_n = ~dsel_q;
    end
    if (clr) begin
      fsel_n = 1'b0;
      dsel_n = 1'b0;
      ridx_n = '0;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NBUF; i++) begin
        st_q[i]  <= BUF_OPEN;
        cnt_q[i] <= '0;
      end
      fsel_q <= 1'b0;
      dsel_q <= 1'b0;
      ridx_q <= '0;
    end else begin
      for (int i = 0; i < NBUF; i++) begin
        st_q[i]  <= st_n[i];
        cnt_q[i] <= cnt_n[i];
      end
      fsel_q <= fsel_n;
      dsel_q <= dsel_n;
      ridx_q <= ridx_n;
    end
  end

  // outputs
  always_comb begin
    buf_empty = 1'b0;
    for (int i = 0; i < NBUF; i++) begin
      wr_en[i] = wr_go & (int'(fsel_q) == i);
      if ((st_q[i] == BUF_OPEN) && (cnt_q[i] == '0)) buf_empty = 1'b1;
    end
  end

  assign wr_addr  = fill_cnt[AW-1:0];
  assign rd_addr  = ridx_q[AW-1:0];
  assign rd_sel   = dsel_q;
  assign tx_valid = drn_ready;
  assign tx_count = drn_cnt;
endmodule

// File: rtl/ep_txdb_fifo.sv
module ep_txdb_fifo
  import ep_tx_pkg::*;
#(
  parameter  int unsigned DEPTH = 64,
  localparam int unsigned CW    = $clog2(DEPTH + 1),
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  input  logic              cpu_commit,
  input  logic              cpu_clear,
  input  logic              irq_en,
  output logic              dma_req,
  input  logic              dma_ack,
  input  logic [BYTE_W-1:0] dma_data,
  output logic              tx_valid,
  output logic [CW-1:0]     tx_count,
  output logic [BYTE_W-1:0] tx_data,
  input  logic              tx_rd,
  input  logic              tx_done,
  output logic              buf_empty,
  output logic              irq
);
  logic              dma_en, clr_hold, rd_sel;
  logic [NBUF-1:0]   wr_en;
  logic [AW-1:0]     wr_addr, rd_addr;
  logic [BYTE_W-1:0] bank_rd [NBUF];

  ep_tx_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cpu_clear (cpu_clear),
    .cfg_rdata (cfg_rdata),
    .dma_en    (dma_en),
    .clr_hold  (clr_hold)
  );

  ep_tx_seq #(.DEPTH(DEPTH)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (cpu_clear),
    .dma_en     (dma_en),
    .hold       (clr_hold),
    .dma_ack    (dma_ack),
    .cpu_commit (cpu_commit),
    .tx_rd      (tx_rd),
    .tx_done    (tx_done),
    .dma_req    (dma_req),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .rd_sel     (rd_sel),
    .rd_addr    (rd_addr),
    .tx_valid   (tx_valid),
    .tx_count   (tx_count),
    .buf_empty  (buf_empty)
  );

  for (genvar g = 0; g < NBUF; g++) begin : g_bank
    ep_tx_bank #(.DEPTH(DEPTH), .DW(BYTE_W)) u_bank (
      .clk     (clk),
      .wr_en   (wr_en[g]),
      .wr_addr (wr_addr),
      .wr_data (dma_data),
      .rd_addr (rd_addr),
      .rd_data (bank_rd[g])
    );
  end

  assign tx_data = bank_rd[rd_sel];
  assign irq     = buf_empty & irq_en;
endmodule

// File: rtl/ep_txdb_fifo_chk.sv
module ep_txdb_fifo_chk #(
  parameter  int unsigned DEPTH = 64,
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [7:0]    cfg_rdata,
  input logic          cpu_clear,
  input logic          irq_en,
  input logic          dma_req,
  input logic          tx_valid,
  input logic [CW-1:0] tx_count,
  input logic          tx_done,
  input logic          buf_empty,
  input logic          irq
);
  a_r1_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata & 8'hFD) == 8'h00);

  a_r2_req_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> cfg_rdata[1]);

  a_r9_clear_gap: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_clear |=> !dma_req);

  a_r4_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (tx_count != '0) && (tx_count <= CW'(DEPTH)));

  a_r8_hold_packet: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_done && !cpu_clear) |=> tx_valid && $stable(tx_count));

  a_r10_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> buf_empty && irq_en);
endmodule

bind ep_txdb_fifo ep_txdb_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_rdata (cfg_rdata),
  .cpu_clear (cpu_clear),
  .irq_en    (irq_en),
  .dma_req   (dma_req),
  .tx_valid  (tx_valid),
  .tx_count  (tx_count),
  .tx_done   (tx_done),
  .buf_empty (buf_empty),
  .irq       (irq)
);

// File: tb/sim_ep_txdb_fifo.sv
module sim_ep_txdb_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_we, cpu_commit, cpu_clear, irq_en, dma_ack, tx_rd, tx_done;
  logic [7:0] cfg_wdata, dma_data;
  logic [7:0] cfg_rdata, tx_data;
  logic [6:0] tx_count;
  logic       dma_req, tx_valid, buf_empty, irq;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 1'b0;
  bit mon_on = 1'b0;
  logic [7:0] exp_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ep_txdb_fifo u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .cpu_commit(cpu_commit), .cpu_clear(cpu_clear),
    .irq_en(irq_en), .dma_req(dma_req), .dma_ack(dma_ack), .dma_data(dma_data),
    .tx_valid(tx_valid), .tx_count(tx_count), .tx_data(tx_data), .tx_rd(tx_rd),
    .tx_done(tx_done), .buf_empty(buf_empty), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // driver: DMA writes; accepted bytes go to the scoreboard queue
  task automatic fill(input int n, input logic [7:0] base);
    for (int i = 0; i < n; i++) begin
      dma_ack  = 1'b1;
      dma_data = base + 8'(i);
      if (dma_req) exp_q.push_back(dma_data);
      step();
    end
    dma_ack = 1'b0;
  endtask

  task automatic read_bytes(input int n);
    mon_on = 1'b1;
    for (int i = 0; i < n; i++) begin
      tx_rd = 1'b1;
      step();
    end
    tx_rd  = 1'b0;
    mon_on = 1'b0;
  endtask

  task automatic send_done();
    tx_done = 1'b1;
    step();
    tx_done = 1'b0;
  endtask

  task automatic drain(input int len, input string req);
    chk(tx_valid == 1'b1, req, int'(tx_valid), 1);
    chk(int'(tx_count) == len, req, int'(tx_count), len);
    read_bytes(len);
    send_done();
  endtask

  task automatic cfg_write(input logic [7:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    step();
    cfg_we = 1'b0;
  endtask

  // monitor: compares each byte read against the scoreboard (R7)
  always @(negedge clk) begin
    if (mon_on && tx_rd) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7 empty scoreboard", int'(tx_data), -1);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        chk(tx_data == e, "R7 byte order", int'(tx_data), int'(e));
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !done) begin
      chk(1'b0, "watchdog", cyc, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 0; cfg_wdata = 0; cpu_commit = 0; cpu_clear = 0;
    irq_en = 0; dma_ack = 0; dma_data = 0; tx_rd = 0; tx_done = 0;
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R1 reset state
    chk(cfg_rdata == 8'h00, "R1 reset cfg", int'(cfg_rdata), 0);
    chk(dma_req == 1'b0, "R2 reset req", int'(dma_req), 0);
    chk(tx_valid == 1'b0, "R4 reset valid", int'(tx_valid), 0);
    chk(buf_empty == 1'b1, "R10 reset empty", int'(buf_empty), 1);
    chk(irq == 1'b0, "R10 irq masked", int'(irq), 0);
    irq_en = 1'b1; #1;
    chk(irq == 1'b1, "R10 irq with dma off", int'(irq), 1);

    // R3: ack without request stores nothing
    dma_ack = 1'b1; dma_data = 8'hAA; step(); dma_ack = 1'b0;

    // R1: only bit 1 sticks
    cfg_write(8'hFF);
    chk(cfg_rdata == 8'h02, "R1 reserved bits", int'(cfg_rdata), 2);
    chk(dma_req == 1'b1, "R2 req enabled", int'(dma_req), 1);
    chk(irq == 1'b1, "R10 irq not masked by dma", int'(irq), 1);

    // R11: commit together with the 5th byte
    fill(4, 8'h10);
    dma_ack = 1'b1; dma_data = 8'h14; cpu_commit = 1'b1;
    exp_q.push_back(8'h14);
    step();
    dma_ack = 1'b0; cpu_commit = 1'b0;
    drain(5, "R11 commit with byte");
    chk(tx_valid == 1'b0, "R8 freed", int'(tx_valid), 0);
    chk(buf_empty == 1'b1, "R10 empty after drain", int'(buf_empty), 1);

    // R6: commit with zero bytes ignored
    cpu_commit = 1'b1; step(); cpu_commit = 1'b0;
    chk(tx_valid == 1'b0, "R6 empty commit ignored", int'(tx_valid), 0);

    // R4/R5: full packet commits itself, request continues
    fill(63, 8'h40);
    chk(tx_valid == 1'b0, "R4 63 bytes not committed", int'(tx_valid), 0);
    fill(1, 8'h7F);
    chk(tx_valid == 1'b1, "R4 auto commit", int'(tx_valid), 1);
    chk(int'(tx_count) == 64, "R4 count", int'(tx_count), 64);
    chk(dma_req == 1'b1, "R5 request continues", int'(dma_req), 1);

    // R6/R7: short packet behind a full one
    fill(7, 8'h90);
    chk(buf_empty == 1'b0, "R10 no empty buffer", int'(buf_empty), 0);
    chk(irq == 1'b0, "R10 irq low", int'(irq), 0);
    drain(64, "R7 first packet");
    chk(tx_valid == 1'b0, "R6 short not auto", int'(tx_valid), 0);
    cpu_commit = 1'b1; step(); cpu_commit = 1'b0;
    chk(int'(tx_count) == 7, "R6 cpu commit", int'(tx_count), 7);

    // R8: early done ignored
    send_done();
    chk(tx_valid == 1'b1, "R8 early done", int'(tx_valid), 1);
    read_bytes(2);
    send_done();
    chk(int'(tx_count) == 7, "R8 partial done", int'(tx_count), 7);
    read_bytes(5);
    send_done();
    chk(tx_valid == 1'b0, "R8 final done", int'(tx_valid), 0);

    // R2/R5/R3: two full packets back to back, then request drops
    fill(64, 8'h20);
    fill(64, 8'hC0);
    chk(dma_req == 1'b0, "R2 both committed", int'(dma_req), 0);
    fill(3, 8'hEE);
    drain(64, "R7 packet A");
    chk(dma_req == 1'b1, "R5 request after free", int'(dma_req), 1);
    drain(64, "R3 packet B no extra");

    // R9: clear
    fill(5, 8'h55);
    cpu_clear = 1'b1; step(); cpu_clear = 1'b0;
    exp_q.delete();
    chk(dma_req == 1'b0, "R9 request gap", int'(dma_req), 0);
    chk(tx_valid == 1'b0, "R9 no packet", int'(tx_valid), 0);
    chk(buf_empty == 1'b1, "R9 empty", int'(buf_empty), 1);
    step();
    chk(dma_req == 1'b1, "R9 request back", int'(dma_req), 1);
    fill(2, 8'h33);
    cpu_commit = 1'b1; step(); cpu_commit = 1'b0;
    drain(2, "R9 pointers reset");

    // R1/R10: disable
    cfg_write(8'h00);
    chk(dma_req == 1'b0, "R2 disabled", int'(dma_req), 0);
    chk(cfg_rdata == 8'h00, "R1 cleared", int'(cfg_rdata), 0);
    irq_en = 1'b0; #1;
    chk(irq == 1'b0, "R10 irq disabled", int'(irq), 0);
    chk(exp_q.size() == 0, "R7 scoreboard drained", exp_q.size(), 0);

    finish_run();
  end
endmodule